// File: doc/BRIEF.md
# Five-source vectored interrupt controller

This block gathers five interrupt request inputs (named S, A, B, C and D), filters them through a software-written 8-bit enable register, and tracks which sources are currently being serviced. It drives one interrupt line toward a Z80-style processor. During the acknowledge cycle it supplies the vector byte of the winning source. A one-cycle end-of-service pulse, raised when the processor executes either an EI or a RETI instruction, retires the most important source that is still in service.

Requests follow the input levels. A source posts a request when its input goes high and withdraws it when its input goes low. An acknowledge consumes the request, so an input that stays high does not interrupt again until it has gone low and high once more. The enable register is loaded through a write strobe and a data byte. Writing bit 7 from 0 to 1 also drops any pending request from S.

Top module: `irq_vec5_ctrl`

## Requirements
- R1: Source inputs use index order S=0, A=1, B=2, C=3, D=4. In the enable register, S is enabled by bit 4 and A, B, C and D by bits 0, 1, 2 and 3. Bits 5 and 6 enable nothing.
- R2: The request for a source is set at the clock edge that samples its input rising, and is cleared at the edge that samples its input falling. An input held high posts no new request after its request was consumed.
- R3: `irq_o` is a register that is updated at every clock edge. After each edge it is high exactly when some source has its request set, its enable bit set and its in-service bit clear.
- R4: Fixed priority, from highest to lowest, is S, A, B, C, D. `vector_o` always shows the vector of the highest-priority qualifying source.
- R5: The vectors are 0xF0 for S, 0xF2 for A, 0xF4 for B, 0xF6 for C and 0xF8 for D.
- R6: When no source qualifies, `vector_o` is 0xFF.
- R7: At an edge where `ack_i` is high, the winning source has its request cleared and its in-service bit set. With nothing qualifying, the acknowledge changes no state.
- R8: At an edge where `eoi_i` is high, only the highest-priority in-service bit is cleared.
- R9: A write that changes enable bit 7 from 0 to 1 clears the request of S. A write of bit 7 while it is already 1 does not.
- R10: A synchronous reset (`rst_n` low at an edge) clears the enable, request, in-service and sampled-level state. Afterwards `irq_o` is 0 and `vector_o` is 0xFF.
- R11: When `ack_i` and `eoi_i` are high in the same cycle, both take effect. The end-of-service pulse acts on the in-service bits held before the edge. The acknowledge clear of a request overrides an input rise and a set from the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 5 | Request levels, index 0=S, 1=A, 2=B, 3=C, 4=D |
| mask_wr_i | input | 1 | Enable register write strobe |
| mask_data_i | input | 8 | Enable register write data |
| ack_i | input | 1 | Interrupt acknowledge cycle |
| eoi_i | input | 1 | End-of-service pulse (EI or RETI executed) |
| irq_o | output | 1 | Registered interrupt line |
| vector_o | output | 8 | Vector of the current winner, 0xFF if none |

## Verification
Two operations can fall in the same cycle: an acknowledge, which grants a new source, and an end-of-service pulse, which retires a source already in service. The bench provokes this overlap on purpose, first with an empty in-service set and then with S in service while A is being acknowledged. Random stimulus also raises both strobes together many times. In each case it compares the vector and the interrupt line in the following cycles with a bench model that applies the retire step to the old in-service bits and then adds the grant. Same-cycle enable writes with bit 7 rising, and input edges that coincide with an acknowledge, are judged by the same model.

// File: rtl/irqv_pkg.sv
// Package: shared helpers for the five-source vectored interrupt controller.
// Assumes source index order equals priority order (index 0 highest).
package irqv_pkg;

    // Bit position in the enable register for a source in priority order:
    // the top-priority source sits above all the others.
    function automatic int unsigned reg_pos(input int unsigned idx, input int unsigned nsrc);
        return (idx == 0) ? (nsrc - 1) : (idx - 1);
    endfunction

endpackage

// File: rtl/irqv_pick.sv
// Module: first-one finder in priority order (index 0 highest).
// Purely combinational; assumes N >= 1.
module irqv_pick #(
    parameter int unsigned N  = 5,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand_i,
    output logic [N-1:0]  first_oh_o,
    output logic [IW-1:0] first_idx_o,
    output logic          any_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1]     = seen[i] | cand_i[i];
        assign first_oh_o[i] = cand_i[i] & ~seen[i];
    end

    assign any_o = seen[N];

    // Encode the one-hot winner into an index.
    always_comb begin
        first_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (first_oh_o[i]) first_idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irqv_req_track.sv
// Module: per-source request register driven by input level transitions.
// Assumes request inputs are synchronous to clk. Clears from an acknowledge
// or from the enable-arm event override a same-edge input rise.
module irqv_req_track #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] ack_clr_i,
    input  logic [N-1:0] arm_clr_i,
    output logic [N-1:0] req_q_o,
    output logic [N-1:0] req_nx_o
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        // Next request: clears win, then rise sets, fall clears, else hold.
        always_comb begin
            if (ack_clr_i[i] || arm_clr_i[i])  req_nx_o[i] = 1'b0;
            else if (lvl_i[i] && !prev_q[i])   req_nx_o[i] = 1'b1;
            else if (!lvl_i[i] && prev_q[i])   req_nx_o[i] = 1'b0;
            else                               req_nx_o[i] = req_q_o[i];
        end

        // Hold the sampled level and the request bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i]  <= 1'b0;
                req_q_o[i] <= 1'b0;
            end else begin
                prev_q[i]  <= lvl_i[i];
                req_q_o[i] <= req_nx_o[i];
            end
        end
    end
endmodule

// File: rtl/irqv_svc_track.sv
// Module: in-service register. A retire pulse clears the given one-hot bit
// (taken from the pre-edge state) and an acknowledge sets the granted bit.
module irqv_svc_track #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_i,
    input  logic [N-1:0] grant_oh_i,
    input  logic         eoi_i,
    input  logic [N-1:0] retire_oh_i,
    output logic [N-1:0] isv_q_o,
    output logic [N-1:0] isv_nx_o
);
    // Next in-service set: retire first, then add the new grant.
    always_comb begin
        isv_nx_o = isv_q_o;
        if (eoi_i) isv_nx_o = isv_nx_o & ~retire_oh_i;
        if (ack_i) isv_nx_o = isv_nx_o | grant_oh_i;
    end

    // Hold the in-service bits.
    always_ff @(posedge clk) begin
        if (!rst_n) isv_q_o <= '0;
        else        isv_q_o <= isv_nx_o;
    end
endmodule

// File: rtl/irq_vec5_ctrl.sv
// Module: five-source vectored interrupt controller (top).
// Holds the enable register, resolves fixed priority combinationally so the
// vector is valid throughout the acknowledge cycle, and registers the
// interrupt line from the next-state qualify set. Assumes all inputs are
// synchronous to clk and that ack_i / eoi_i are single-cycle pulses.
module irq_vec5_ctrl #(
    parameter int unsigned NSRC     = 5,
    parameter int unsigned MASK_W   = 8,
    parameter int unsigned ARM_BIT  = 7,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 'hF0,
    parameter int unsigned VEC_STEP = 2,
    parameter int unsigned VEC_NONE = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req_i,
    input  logic              mask_wr_i,
    input  logic [MASK_W-1:0] mask_data_i,
    input  logic              ack_i,
    input  logic              eoi_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vector_o
);
    localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [MASK_W-1:0] mask_q, mask_nx;
    logic [NSRC-1:0]   en_q, en_nx;
    logic [NSRC-1:0]   req_q, req_nx, isv_q, isv_nx;
    logic [NSRC-1:0]   qual, grant_oh, retire_oh, ack_clr, arm_clr;
    logic [IW-1:0]     grant_idx, retire_idx;
    logic              grant_any, retire_any, arm_rise;

    // Enable register next value.
    assign mask_nx = mask_wr_i ? mask_data_i : mask_q;

    // Hold the enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_nx;
    end

    // Remap enable bits from register layout into priority order.
    for (genvar i = 0; i < NSRC; i++) begin : g_remap
        assign en_q[i]  = mask_q[irqv_pkg::reg_pos(i, NSRC)];
        assign en_nx[i] = mask_nx[irqv_pkg::reg_pos(i, NSRC)];
    end

    assign qual     = req_q & en_q & ~isv_q;
    assign arm_rise = mask_wr_i & mask_data_i[ARM_BIT] & ~mask_q[ARM_BIT];
    assign ack_clr  = ack_i ? grant_oh : '0;
    assign arm_clr  = {{(NSRC-1){1'b0}}, arm_rise};

    irqv_pick #(.N(NSRC)) u_grant (
        .cand_i      (qual),
        .first_oh_o  (grant_oh),
        .first_idx_o (grant_idx),
        .any_o       (grant_any)
    );

    irqv_pick #(.N(NSRC)) u_retire (
        .cand_i      (isv_q),
        .first_oh_o  (retire_oh),
        .first_idx_o (retire_idx),
        .any_o       (retire_any)
    );

    irqv_req_track #(.N(NSRC)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (src_req_i),
        .ack_clr_i (ack_clr),
        .arm_clr_i (arm_clr),
        .req_q_o   (req_q),
        .req_nx_o  (req_nx)
    );

    irqv_svc_track #(.N(NSRC)) u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .grant_oh_i  (grant_oh),
        .eoi_i       (eoi_i & retire_any),
        .retire_oh_i (retire_oh),
        .isv_q_o     (isv_q),
        .isv_nx_o    (isv_nx)
    );

    // Vector of the current winner, or the no-source code.
    always_comb begin
        if (grant_any) vector_o = VEC_W'(VEC_BASE + VEC_STEP * 32'(grant_idx));
        else           vector_o = VEC_W'(VEC_NONE);
    end

    // Register the interrupt line from the state being loaded this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(req_nx & en_nx & ~isv_nx);
    end

    logic unused_ok;
    assign unused_ok = ^retire_idx;
endmodule

// File: rtl/irqv_chk.sv
// Checker: port-level properties of irq_vec5_ctrl, attached by bind.
module irqv_chk #(
    parameter int unsigned NSRC     = 5,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 'hF0,
    parameter int unsigned VEC_STEP = 2,
    parameter int unsigned VEC_NONE = 'hFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             eoi_i,
    input logic             irq_o,
    input logic [VEC_W-1:0] vector_o
);
    logic was_rst_q;

    // Remember that the previous edge applied reset.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
        // R10
        if (was_rst_q) begin
            irq_low_after_rst_chk: assert (!irq_o);
        end
    end

    // R6
    none_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (32'(vector_o) == VEC_NONE));

    // R3
    irq_has_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (32'(vector_o) != VEC_NONE));

    // R5
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(vector_o) == VEC_NONE) ||
        ((32'(vector_o) >= VEC_BASE) &&
         (32'(vector_o) <= VEC_BASE + VEC_STEP * (NSRC - 1)) &&
         ((32'(vector_o) - VEC_BASE) % VEC_STEP == 0)));

    // R7
    ack_moves_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !eoi_i) |=> (vector_o != $past(vector_o)));
endmodule

bind irq_vec5_ctrl irqv_chk #(
    .NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP), .VEC_NONE(VEC_NONE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .eoi_i(eoi_i),
    .irq_o(irq_o), .vector_o(vector_o)
);

// File: tb/irq_vec5_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec5_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] src;
    logic       mwr;
    logic [7:0] mdat;
    logic       ack, eoi;
    logic       irq;
    logic [7:0] vec;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    // Bench model, register layout (S=bit4, A..D=bits0..3)
    logic [7:0] m_mask, m_req, m_isv;
    logic [4:0] m_prev;

    always #2.5 clk = ~clk;

    irq_vec5_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src), .mask_wr_i(mwr),
        .mask_data_i(mdat), .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .vector_o(vec)
    );

    function automatic int bpos(input int i);
        return (i == 0) ? 4 : i - 1;
    endfunction

    function automatic int m_win();
        for (int i = 0; i < 5; i++)
            if (m_req[bpos(i)] && m_mask[bpos(i)] && !m_isv[bpos(i)]) return i;
        return -1;
    endfunction

    function automatic int m_first_isv();
        for (int i = 0; i < 5; i++)
            if (m_isv[bpos(i)]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] m_vec();
        int w;
        w = m_win();
        return (w < 0) ? 8'hFF : 8'(8'hF0 + 2 * w);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, check vector, update model, check irq.
    task automatic step(input logic [4:0] lvl, input logic we, input logic [7:0] wd,
                        input logic ak, input logic eo, input string tag);
        int w, e;
        logic [7:0] nreq, nisv, nmask;
        @(negedge clk);
        src = lvl; mwr = we; mdat = wd; ack = ak; eoi = eo;
        #1;
        chk({"R4 R5 R6 vector ", tag}, vec, m_vec());
        w = m_win();
        e = m_first_isv();
        nreq = m_req;
        for (int i = 0; i < 5; i++) begin
            if (lvl[i] && !m_prev[i]) nreq[bpos(i)] = 1'b1;
            if (!lvl[i] && m_prev[i]) nreq[bpos(i)] = 1'b0;
        end
        if (ak && w >= 0) nreq[bpos(w)] = 1'b0;
        if (we && wd[7] && !m_mask[7]) nreq[4] = 1'b0;
        nisv = m_isv;
        if (eo && e >= 0) nisv[bpos(e)] = 1'b0;
        if (ak && w >= 0) nisv[bpos(w)] = 1'b1;
        nmask = we ? wd : m_mask;
        @(posedge clk);
        #1;
        m_req = nreq; m_isv = nisv; m_mask = nmask; m_prev = lvl;
        chk({"R3 irq ", tag}, {7'b0, irq}, {7'b0, |(m_req & m_mask & ~m_isv & 8'h1F)});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src = '0; mwr = 1'b0; mdat = '0; ack = 1'b0; eoi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_mask = '0; m_req = '0; m_isv = '0; m_prev = '0;
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] lv;
        void'($urandom(32'd20250611));
        do_reset();
        #1;
        chk("R10 irq after reset", {7'b0, irq}, 8'h00);
        chk("R10 vector after reset", vec, 8'hFF);

        // R1 R4 R5: all sources up, S wins with F0
        step(5'h00, 1'b1, 8'h1F, 1'b0, 1'b0, "R1 enable");
        step(5'h1F, 1'b0, 8'h00, 1'b0, 1'b0, "R2 rise all");
        #1 chk("R4 S highest", vec, 8'hF0);
        // R7: acknowledges walk down the priority list
        step(5'h1F, 1'b0, 8'h00, 1'b1, 1'b0, "R7 ack S");
        #1 chk("R7 A next", vec, 8'hF2);
        step(5'h1F, 1'b0, 8'h00, 1'b1, 1'b0, "R7 ack A");
        step(5'h1F, 1'b0, 8'h00, 1'b1, 1'b0, "R7 ack B");
        #1 chk("R5 C vector", vec, 8'hF6);
        // R8: retire clears S only; held S input does not re-request (R2)
        step(5'h1F, 1'b0, 8'h00, 1'b0, 1'b1, "R8 retire S");
        #1 chk("R2 held S no rerequest", vec, 8'hF6);
        // R1: bits 5 and 6 enable nothing
        step(5'h1F, 1'b1, 8'h60, 1'b0, 1'b0, "R1 upper bits");
        #1 chk("R1 R6 upper bits no source", vec, 8'hFF);
        chk("R1 irq low", {7'b0, irq}, 8'h00);
        step(5'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R8 retire");
        step(5'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R8 retire");
        // R9: rising bit 7 clears S request
        step(5'h00, 1'b1, 8'h10, 1'b0, 1'b0, "R9 en S");
        step(5'h01, 1'b0, 8'h00, 1'b0, 1'b0, "R9 S up");
        #1 chk("R9 S pending", vec, 8'hF0);
        step(5'h01, 1'b1, 8'h90, 1'b0, 1'b0, "R9 arm");
        #1 chk("R9 arm clears S", vec, 8'hFF);
        step(5'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R9 S down");
        step(5'h01, 1'b0, 8'h00, 1'b0, 1'b0, "R9 S up again");
        step(5'h01, 1'b1, 8'h91, 1'b0, 1'b0, "R9 rewrite bit7");
        #1 chk("R9 no clear when bit7 held", vec, 8'hF0);
        // R11: ack and retire in the same cycle
        step(5'h01, 1'b0, 8'h00, 1'b1, 1'b1, "R11 ack+eoi empty");
        step(5'h03, 1'b0, 8'h00, 1'b0, 1'b0, "R11 A up");
        #1 chk("R11 A qualifies", vec, 8'hF2);
        step(5'h03, 1'b0, 8'h00, 1'b1, 1'b1, "R11 ack A retire S");
        step(5'h02, 1'b0, 8'h00, 1'b0, 1'b0, "R11 S down");
        step(5'h03, 1'b0, 8'h00, 1'b0, 1'b0, "R11 S up");
        #1 chk("R11 S free again", vec, 8'hF0);
        // R7: ack with nothing qualifying changes nothing
        step(5'h00, 1'b1, 8'h00, 1'b0, 1'b0, "R7 disable all");
        step(5'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R7 empty ack");
        step(5'h00, 1'b1, 8'h91, 1'b0, 1'b0, "R7 re-enable");

        // Random mix
        lv = 5'h00;
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < 5; i++)
                if ($urandom_range(7) == 0) lv[i] = ~lv[i];
            step(lv, ($urandom_range(9) == 0), 8'($urandom),
                 ($urandom_range(2) == 0), ($urandom_range(5) == 0), "R2 R7 R8 R11 random");
        end

        // R10: reset mid-activity
        do_reset();
        #1;
        chk("R10 irq after second reset", {7'b0, irq}, 8'h00);
        chk("R10 vector after second reset", vec, 8'hFF);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule